// File: doc/BRIEF.md
# Receive Character Queue with Automatic Request-to-Send Pacing

This block sits between the receive shifter of a serial port and the host. Every character that the shifter finishes is written into a first-in, first-out store. Three error flags that belong to the character travel with it through the store. The host pops characters one at a time. Each popped character comes back with its own flags, and the current fill count is always visible.

The block also drives the active-low request-to-send line, which tells the far end when to pause. With automatic pacing armed, the line goes inactive (high) once the fill climbs to a halt threshold. It becomes active (low) again only after the host has drained the store to a lower resume threshold. Characters that still arrive while the line is inactive are stored normally.

Software arms the pacing by setting the enable bit and then asserting request-to-send through the manual bit. There are two interrupts. A receive interrupt reports that the fill has reached a programmed trigger level. A sticky flag reports each time the line rises from low to high.

Top module: `rx_fifo_rts`

## Requirements
- R1: The store holds up to 64 entries and `fill` reports the entry count. An accepted write adds one, a successful read removes one, and doing both in one cycle leaves the count unchanged.
- R2: The read strobe returns entries in the order they were written. From the next cycle, `rd_data` shows the oldest character and `rd_err` shows the 3 flags written with it. A read while empty leaves `rd_data`, `rd_err` and `fill` unchanged.
- R3: A write while `fill` is 64 is discarded and sets the sticky `overrun` output. A set is kept until a cycle with `stat_rd` high and no new discard.
- R4: The halt level is `flow_lvl[3:0]`×4 and the resume level is `flow_lvl[7:4]`×4. Pacing is armed while `auto_rts_en` and `rts_manual` are both 1. While armed, `rts_n` goes high the cycle after `fill` is at or above the halt level, and never while `fill` is below it.
- R5: While armed, once `rts_n` is high it returns low the cycle after `fill` is at or below the resume level. Between the two levels it holds its value.
- R6: Writes are accepted while `rts_n` is high, exactly as while it is low.
- R7: With `auto_rts_en` at 0, `rts_n` becomes the inverse of `rts_manual` one cycle later. With `auto_rts_en` at 1 and `rts_manual` at 0, `rts_n` is high and the hysteresis state is cleared.
- R8: When `rts_irq_en` is 1, every low-to-high change of `rts_n` sets `rts_irq` in the same cycle. The flag stays set until a cycle with `stat_rd` high, and a new rise in that cycle wins over the clear.
- R9: `rx_irq` is high exactly when `fifo_en`, `rx_irq_en` are 1 and `fill` is at least `trig_lvl`. It drops as soon as `fill` falls below that level.
- R10: After reset, `fill`, `rd_data`, `rd_err`, `overrun`, `rts_irq` and `rx_irq` are 0, and `rts_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Character write strobe from the shifter |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags of the character |
| rd_en | input | 1 | Host pop strobe |
| stat_rd | input | 1 | Host status read; clears sticky flags |
| fifo_en | input | 1 | Queue enable; gates the receive interrupt |
| auto_rts_en | input | 1 | Automatic pacing enable |
| rts_manual | input | 1 | Software request-to-send (1 = assert) |
| flow_lvl | input | 8 | Resume level in [7:4], halt level in [3:0], units of 4 |
| trig_lvl | input | 7 | Receive interrupt fill threshold |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rts_irq_en | input | 1 | Request-to-send change interrupt enable |
| rd_data | output | 8 | Popped character |
| rd_err | output | 3 | Error flags of popped character |
| fill | output | 7 | Current entry count, 0 to 64 |
| overrun | output | 1 | Sticky discarded-write flag |
| rts_n | output | 1 | Active-low request-to-send |
| rx_irq | output | 1 | Fill at or above trigger level |
| rts_irq | output | 1 | Sticky request-to-send rise flag |

## Verification
Some properties are checked on every cycle. The fill count never exceeds 64 and moves by at most one per cycle. A write into a non-full store always lands, whatever the line state. The overrun and rise flags stay set until they are cleared. The line follows the manual bit when pacing is off and never rises early while armed. The receive interrupt stays low with the queue disabled. Only the bench scenarios show the rest: data and flag ordering through the store, the exact cycles of the halt and resume edges around the two thresholds, the overflow discard, and status reads that clear the flags. A behavioural queue model compares against every output in every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int CHAR_W = 8;
    localparam int FLAG_W = 3;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [CHAR_W-1:0] char;
    } rxf_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  rxf_entry_t       wr_ent,
    input  logic             rd_en,
    output rxf_entry_t       rd_ent,
    output logic [CNT_W-1:0] count,
    output logic             drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
        rxf_entry_t       rd_ent;
    } store_st_t;

    store_st_t  st_d, st_q;
    rxf_entry_t mem [DEPTH];
    logic       do_wr, do_rd;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d  = st_q;
        do_rd = rd_en && (st_q.count != '0);
        do_wr = wr_en && (st_q.count != FULL_CNT);
        drop  = wr_en && !do_wr;
        if (do_rd) begin
            st_d.rd_ent = mem[st_q.rptr];
            st_d.rptr   = ptr_inc(st_q.rptr);
        end
        if (do_wr) begin
            st_d.wptr = ptr_inc(st_q.wptr);
        end
        unique case ({do_wr, do_rd})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wptr] <= wr_ent;
    end

    assign rd_ent = st_q.rd_ent;
    assign count  = st_q.count;
endmodule

// File: rtl/rxf_rts_ctl.sv
module rxf_rts_ctl #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             auto_en,
    input  logic             manual,
    input  logic [CNT_W-1:0] halt_lvl,
    input  logic [CNT_W-1:0] resume_lvl,
    output logic             rts_n,
    output logic             rts_rise
);
    typedef struct packed {
        logic halted;
        logic rts_n;
    } rts_st_t;

    rts_st_t st_d, st_q;
    logic    armed;

    always_comb begin
        st_d  = st_q;
        armed = auto_en && manual;
        if (!armed) begin
            st_d.halted = 1'b0;
        end else if (st_q.halted) begin
            st_d.halted = !(count <= resume_lvl);
        end else begin
            st_d.halted = (count >= halt_lvl);
        end
        st_d.rts_n = armed ? st_d.halted : !manual;
        rts_rise   = st_d.rts_n && !st_q.rts_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{halted: 1'b0, rts_n: 1'b1};
        else        st_q <= st_d;
    end

    assign rts_n = st_q.rts_n;
endmodule

// File: rtl/rxf_status.sv
module rxf_status #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop,
    input  logic             stat_rd,
    input  logic             rts_rise,
    input  logic             rts_irq_en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic             fifo_en,
    input  logic             rx_irq_en,
    output logic             overrun,
    output logic             rts_irq,
    output logic             rx_irq
);
    typedef struct packed {
        logic overrun;
        logic rts_flag;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (drop)         st_d.overrun = 1'b1;
        else if (stat_rd) st_d.overrun = 1'b0;
        if (rts_rise && rts_irq_en) st_d.rts_flag = 1'b1;
        else if (stat_rd)           st_d.rts_flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overrun = st_q.overrun;
    assign rts_irq = st_q.rts_flag;
    assign rx_irq  = fifo_en && rx_irq_en && (count >= trig_lvl);
endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts
    import rxf_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int LVL_W     = 4,
    parameter int LVL_SCALE = 4,
    parameter int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CHAR_W-1:0]   wr_data,
    input  logic [FLAG_W-1:0]   wr_err,
    input  logic                rd_en,
    input  logic                stat_rd,
    input  logic                fifo_en,
    input  logic                auto_rts_en,
    input  logic                rts_manual,
    input  logic [2*LVL_W-1:0]  flow_lvl,
    input  logic [CNT_W-1:0]    trig_lvl,
    input  logic                rx_irq_en,
    input  logic                rts_irq_en,
    output logic [CHAR_W-1:0]   rd_data,
    output logic [FLAG_W-1:0]   rd_err,
    output logic [CNT_W-1:0]    fill,
    output logic                overrun,
    output logic                rts_n,
    output logic                rx_irq,
    output logic                rts_irq
);
    rxf_entry_t       wr_ent, rd_ent;
    logic [CNT_W-1:0] count;
    logic             drop, rts_rise;
    logic [CNT_W-1:0] halt_lvl, resume_lvl;

    assign wr_ent     = '{flags: wr_err, char: wr_data};
    assign halt_lvl   = CNT_W'(CNT_W'(flow_lvl[LVL_W-1:0]) * CNT_W'(LVL_SCALE));
    assign resume_lvl = CNT_W'(CNT_W'(flow_lvl[2*LVL_W-1:LVL_W]) * CNT_W'(LVL_SCALE));

    rxf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ent(wr_ent),
        .rd_en(rd_en), .rd_ent(rd_ent), .count(count), .drop(drop)
    );

    rxf_rts_ctl #(.CNT_W(CNT_W)) u_rts (
        .clk(clk), .rst_n(rst_n), .count(count), .auto_en(auto_rts_en),
        .manual(rts_manual), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
        .rts_n(rts_n), .rts_rise(rts_rise)
    );

    rxf_status #(.CNT_W(CNT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .drop(drop), .stat_rd(stat_rd),
        .rts_rise(rts_rise), .rts_irq_en(rts_irq_en), .count(count),
        .trig_lvl(trig_lvl), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en),
        .overrun(overrun), .rts_irq(rts_irq), .rx_irq(rx_irq)
    );

    assign rd_data = rd_ent.char;
    assign rd_err  = rd_ent.flags;
    assign fill    = count;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int DEPTH     = 64,
    parameter int LVL_W     = 4,
    parameter int LVL_SCALE = 4,
    parameter int CNT_W     = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic               stat_rd,
    input logic               fifo_en,
    input logic               auto_rts_en,
    input logic               rts_manual,
    input logic [2*LVL_W-1:0] flow_lvl,
    input logic               rts_irq_en,
    input logic [CNT_W-1:0]   fill,
    input logic               overrun,
    input logic               rts_n,
    input logic               rx_irq,
    input logic               rts_irq
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    logic [CNT_W-1:0] halt_c;
    assign halt_c = CNT_W'(CNT_W'(flow_lvl[LVL_W-1:0]) * CNT_W'(LVL_SCALE));

    a_r1_fill_max: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL);

    a_r1_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fill == $past(fill)) || (fill == CNT_W'($past(fill) + 1'b1))
                 || (fill == CNT_W'($past(fill) - 1'b1)));

    a_r3_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && fill == FULL) |=> (overrun && fill == FULL));

    a_r3_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_rd) |=> overrun);

    a_r4_no_early_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rts_manual && !rts_n && fill < halt_c) |=> !rts_n);

    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && fill < FULL) |=> (fill == CNT_W'($past(fill) + 1'b1)));

    a_r7_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |=> (rts_n == !$past(rts_manual)));

    a_r8_rise_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_irq_en && !rts_n) |=> (!rts_n || rts_irq));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_irq && !stat_rd) |=> rts_irq);

    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !rx_irq);
endmodule

bind rx_fifo_rts rxf_checker #(
    .DEPTH(DEPTH), .LVL_W(LVL_W), .LVL_SCALE(LVL_SCALE), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .stat_rd(stat_rd),
    .fifo_en(fifo_en), .auto_rts_en(auto_rts_en), .rts_manual(rts_manual),
    .flow_lvl(flow_lvl), .rts_irq_en(rts_irq_en), .fill(fill),
    .overrun(overrun), .rts_n(rts_n), .rx_irq(rx_irq), .rts_irq(rts_irq)
);

// File: tb/sim_rx_fifo_rts.sv
module sim_rx_fifo_rts;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, rd_en = 0, stat_rd = 0, fifo_en = 0;
    logic       auto_rts_en = 0, rts_manual = 0, rx_irq_en = 0, rts_irq_en = 0;
    logic [7:0] wr_data = 0, flow_lvl = 0;
    logic [2:0] wr_err = 0;
    logic [6:0] trig_lvl = 0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic [6:0] fill;
    logic       overrun, rts_n, rx_irq, rts_irq;

    int checks = 0, errors = 0;

    logic [10:0] mq[$];
    logic [10:0] m_rd = '0;
    bit m_ovr = 0, m_halt = 0, m_rts = 1, m_flag = 0;

    always #5 clk = ~clk;

    rx_fifo_rts u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
        .rd_en(rd_en), .stat_rd(stat_rd), .fifo_en(fifo_en), .auto_rts_en(auto_rts_en),
        .rts_manual(rts_manual), .flow_lvl(flow_lvl), .trig_lvl(trig_lvl),
        .rx_irq_en(rx_irq_en), .rts_irq_en(rts_irq_en), .rd_data(rd_data),
        .rd_err(rd_err), .fill(fill), .overrun(overrun), .rts_n(rts_n),
        .rx_irq(rx_irq), .rts_irq(rts_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        int  old, halt, res;
        bit  armed, hn, nr, wok, rok;
        @(posedge clk);
        old   = mq.size();
        wok   = wr_en && old < 64;
        rok   = rd_en && old > 0;
        if (rok) m_rd = mq.pop_front();
        if (wok) mq.push_back({wr_err, wr_data});
        if (wr_en && !wok) m_ovr = 1; else if (stat_rd) m_ovr = 0;
        armed = auto_rts_en && rts_manual;
        halt  = int'(flow_lvl[3:0]) * 4;
        res   = int'(flow_lvl[7:4]) * 4;
        if (!armed)      hn = 0;
        else if (m_halt) hn = !(old <= res);
        else             hn = (old >= halt);
        nr = armed ? hn : !rts_manual;
        if (nr && !m_rts && rts_irq_en) m_flag = 1; else if (stat_rd) m_flag = 0;
        m_halt = hn;
        m_rts  = nr;
        #1;
        chk("R1 fill", int'(fill), mq.size());
        chk("R2 data", int'(rd_data), int'(m_rd[7:0]));
        chk("R2 flags", int'(rd_err), int'(m_rd[10:8]));
        chk("R3 overrun", int'(overrun), int'(m_ovr));
        chk(armed ? "R4,R5 rts_n" : "R7 rts_n", int'(rts_n), int'(m_rts));
        chk("R8 rts_irq", int'(rts_irq), int'(m_flag));
        chk("R9 rx_irq", int'(rx_irq),
            int'(fifo_en && rx_irq_en && mq.size() >= int'(trig_lvl)));
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        wr_en = 1; wr_data = d; wr_err = e;
        step();
        wr_en = 0;
    endtask

    task automatic pop();
        rd_en = 1;
        step();
        rd_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 fill", int'(fill), 0);
        chk("R10 rd_data", int'({rd_err, rd_data}), 0);
        chk("R10 overrun", int'(overrun), 0);
        chk("R10 rts_n", int'(rts_n), 1);
        chk("R10 irqs", int'({rts_irq, rx_irq}), 0);
        rst_n = 1;
        step();

        // R1/R2: ordering with flags, read on empty, simultaneous access
        for (int i = 0; i < 5; i++) push(8'h30 + 8'(i), 3'(i + 1));
        for (int i = 0; i < 6; i++) pop();
        chk("R2 empty read keeps data", int'(rd_data), 8'h34);
        wr_en = 1; rd_en = 1; wr_data = 8'hA5; wr_err = 3'b101;
        step();
        wr_en = 1; rd_en = 1; wr_data = 8'h5A; wr_err = 3'b010;
        step();
        wr_en = 0; rd_en = 0;
        chk("R1 simultaneous count", int'(fill), 1);
        pop();

        // R9: trigger interrupt
        fifo_en = 1; rx_irq_en = 1; trig_lvl = 7'd16;
        for (int i = 0; i < 20; i++) push(8'(i * 7), 3'(i));
        chk("R9 above trigger", int'(rx_irq), 1);
        fifo_en = 0; step();
        chk("R9 disabled queue", int'(rx_irq), 0);
        fifo_en = 1;
        for (int i = 0; i < 20; i++) pop();
        chk("R9 below trigger", int'(rx_irq), 0);

        // R3: overflow discard and clear
        for (int i = 0; i < 67; i++) push(8'(i), 3'(i));
        chk("R3 full count", int'(fill), 64);
        chk("R3 overrun set", int'(overrun), 1);
        stat_rd = 1; step(); stat_rd = 0;
        chk("R3 overrun cleared", int'(overrun), 0);
        for (int i = 0; i < 65; i++) pop();
        chk("R3 last kept entry", int'(rd_data), 63);

        // R4/R5/R6/R8: automatic pacing, halt 20, resume 8
        flow_lvl = 8'h25; rts_irq_en = 1; auto_rts_en = 1; rts_manual = 0;
        step(); step();
        chk("R7 armed-off high", int'(rts_n), 1);
        stat_rd = 1; step(); stat_rd = 0;
        rts_manual = 1; step(); step();
        chk("R4 started low", int'(rts_n), 0);
        for (int i = 0; i < 20; i++) push(8'(i + 100), 3'(i));
        chk("R4 still low at edge", int'(rts_n), 0);
        step();
        chk("R4 halted", int'(rts_n), 1);
        chk("R8 flag on rise", int'(rts_irq), 1);
        f0 = int'(fill);
        for (int i = 0; i < 10; i++) push(8'(i + 200), 3'(i));
        chk("R6 writes while halted", int'(fill), f0 + 10);
        stat_rd = 1; step(); stat_rd = 0;
        chk("R8 flag cleared", int'(rts_irq), 0);
        for (int i = 0; i < 21; i++) pop();
        chk("R5 held above resume", int'(rts_n), 1);
        pop(); step();
        chk("R5 resumed", int'(rts_n), 0);
        for (int i = 0; i < 10; i++) pop();

        // R7: manual control
        auto_rts_en = 0; rts_manual = 0; step();
        chk("R7 manual off", int'(rts_n), 1);
        rts_manual = 1; step();
        chk("R7 manual on", int'(rts_n), 0);
        rts_manual = 0; step(); step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule